// File: doc/BRIEF.md
# Binary64 Compare and Scale Unit

This unit performs a small set of binary64 operations that need no floating-point datapath. Each operation works on the encoded 64-bit words with integer logic alone. It compares two operands for strict less-than, flips the sign of one operand, or halves or doubles one operand by moving its exponent field. Only zeros and normal numbers are meant as inputs. Subnormal inputs, infinities and NaNs are outside the supported range. An exponent that leaves the normal range gives an unspecified word, except in the zero cases named below.

A request is presented with `in_valid` together with a 2-bit operation code and two operands. The result word and the less-than flag appear one clock later, marked by `out_valid`. When no request is presented, the output registers keep their last values. A surrounding datapath can issue one request on every cycle.

Top module: `b64_cmpscale`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the unit clears `out_valid`, `result` and `lt_flag` to zero.
- R2: `out_valid` equals `in_valid` as sampled on the previous rising edge. A cycle without `in_valid` leaves `result` and `lt_flag` unchanged.
- R3: Operation code 2'b00 selects compare. When at least one operand has bit 63 clear, `lt_flag` is the signed 64-bit comparison `opa < opb` of the raw encodings.
- R4: In a compare where both operands have bit 63 set, `lt_flag` is the signed 64-bit comparison `opa > opb`. Two equal negative operands therefore give 0.
- R5: A compare of negative zero (0x8000000000000000) against positive zero (0) gives `lt_flag` = 1. The reverse order gives 0.
- R6: Under compare (code 2'b00), `result` is `opa` unchanged.
- R7: Operation code 2'b01 selects negate. `result` is `opa` with bit 63 inverted and bits 62..0 unchanged.
- R8: Operation code 2'b10 selects halve. When the exponent field (bits 62..52) of `opa` is nonzero, `result` is `opa` minus 2^52, which lowers the exponent by one and keeps sign and fraction.
- R9: Under halve, an `opa` whose exponent field is zero, including either signed zero, gives an all-zero `result`.
- R10: Operation code 2'b11 selects double. When the exponent field of `opa` is nonzero, `result` is `opa` plus 2^52 (modulo 2^64).
- R11: Under double, an `opa` whose exponent field is zero is returned unchanged, with its sign kept.
- R12: For any accepted request whose code is not compare, `lt_flag` is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A request is present this cycle |
| op | input | 2 | Operation: 00 compare, 01 negate, 10 halve, 11 double |
| opa | input | 64 | First operand; the operand that is transformed |
| opb | input | 64 | Second operand, used only by compare |
| out_valid | output | 1 | `result` and `lt_flag` hold a new answer |
| result | output | 64 | Transformed operand, or `opa` under compare |
| lt_flag | output | 1 | Strict less-than of `opa` against `opb` |

## Verification
The only state in the unit is the output register stage. A fault there shows up on the first cycle after the request that exposes it. One kind of fault is a lost hold when `in_valid` is low, which appears as a changed `result` on an idle cycle. Another is a stale or wrong operation select, which appears as a wrong word on the very next valid output. Faults in the combinational paths show up at the sign-boundary and zero-exponent inputs. These include the two signed zeros, equal negative operands, and an exponent field of one under halve. The reference model predicts every cycle, so any divergence is caught one clock after the offending request.

// File: rtl/b64su_pkg.sv
// Package: shared widths and the operation code for the binary64
// compare and scale unit.
package b64su_pkg;
    parameter int unsigned WORD_W = 64;
    parameter int unsigned EXP_W  = 11;
    parameter int unsigned FRAC_W = 52;

    typedef enum logic [1:0] {
        OP_CMP  = 2'b00,
        OP_NEG  = 2'b01,
        OP_HALF = 2'b10,
        OP_DBL  = 2'b11
    } b64_op_e;
endpackage

// File: rtl/b64_cmp.sv
// Module: b64_cmp
// Strict less-than of two binary64 encodings using one signed integer
// comparator pair. When both words are negative the order of encodings is
// reversed, so the greater-than result is used instead. Equal words still
// give 0.
// Assumes: operands are zeros or normal numbers; -0 is ordered below +0.
module b64_cmp #(
    parameter int unsigned W = b64su_pkg::WORD_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         lt
);
    logic signed [W-1:0] sa;
    logic signed [W-1:0] sb;
    logic                lt_int;
    logic                gt_int;
    logic                both_neg;

    assign sa = a;
    assign sb = b;

    // Signed integer comparisons of the raw encodings.
    always_comb begin
        lt_int   = (sa < sb);
        gt_int   = (sa > sb);
        both_neg = a[W-1] & b[W-1];
    end

    // Reverse the sense only when both operands carry a set sign bit.
    always_comb begin
        lt = both_neg ? gt_int : lt_int;
    end
endmodule

// File: rtl/b64_scale.sv
// Module: b64_scale
// Single-operand transforms on a binary64 word: pass, negate, halve and
// double. Halve and double move the exponent field by one. A zero
// exponent is handled explicitly, so zeros stay zeros.
// Assumes: normal or zero input; overflow past the top exponent wraps.
module b64_scale
    import b64su_pkg::*;
#(
    parameter int unsigned W  = WORD_W,
    parameter int unsigned EW = EXP_W,
    parameter int unsigned FW = FRAC_W
) (
    input  logic [W-1:0] a,
    input  b64_op_e      op,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] EXP_LSB   = W'(1) << FW;
    localparam logic [W-1:0] SIGN_MASK = W'(1) << (W - 1);

    logic [W-1:0]  neg_w;
    logic [W-1:0]  half_raw;
    logic [W-1:0]  half_w;
    logic [W-1:0]  dbl_w;
    logic [EW-1:0] exp_in;
    logic [EW-1:0] exp_half;

    assign exp_in = a[FW +: EW];

    // Sign inversion touches only the top bit.
    always_comb begin
        neg_w = a ^ SIGN_MASK;
    end

    // Halve: drop exponent by one; a borrow out of a zero exponent leaves
    // an all-ones exponent, which marks the result as zero.
    always_comb begin
        half_raw = a - EXP_LSB;
        exp_half = half_raw[FW +: EW];
        half_w   = (exp_half == {EW{1'b1}}) ? '0 : half_raw;
    end

    // Double: raise exponent by one unless the value is a zero.
    always_comb begin
        dbl_w = (exp_in != '0) ? (a + EXP_LSB) : a;
    end

    // Select the transform named by the operation code.
    always_comb begin
        unique case (op)
            OP_CMP:  res = a;
            OP_NEG:  res = neg_w;
            OP_HALF: res = half_w;
            OP_DBL:  res = dbl_w;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/b64_cmpscale.sv
// Module: b64_cmpscale (top)
// Binary64 compare and scale unit. It accepts one request per cycle and
// returns the result word and the less-than flag one cycle later under
// out_valid. Outputs hold while no request arrives.
// Assumes: synchronous active-low reset; lt_flag is meaningful only for
// compare and reads 0 after other operations.
module b64_cmpscale
    import b64su_pkg::*;
#(
    parameter int unsigned W  = WORD_W,
    parameter int unsigned EW = EXP_W,
    parameter int unsigned FW = FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         lt_flag
);
    localparam logic [W-1:0] NEG_ZERO = W'(1) << (W - 1);

    b64_op_e      op_e;
    logic         cmp_lt;
    logic         lt_next;
    logic [W-1:0] scale_res;

    assign op_e = b64_op_e'(op);

    b64_cmp #(.W(W)) u_cmp (
        .a  (opa),
        .b  (opb),
        .lt (cmp_lt)
    );

    b64_scale #(.W(W), .EW(EW), .FW(FW)) u_scale (
        .a   (opa),
        .op  (op_e),
        .res (scale_res)
    );

    // The flag is forced low for operations other than compare.
    always_comb begin
        lt_next = (op_e == OP_CMP) ? cmp_lt : 1'b0;
    end

    // Output register stage: capture on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            lt_flag   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= scale_res;
                lt_flag <= lt_next;
            end
        end
    end

    // R2
    hold_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(lt_flag)));

    // R5
    neg_zero_below_pos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b00 && opa == NEG_ZERO && opb == '0) |=> lt_flag);

    // R6
    cmp_passes_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b00) |=> (result == $past(opa)));

    // R7
    negate_sign_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b01) |=>
            (result[W-1] != $past(opa[W-1]) && result[W-2:0] == $past(opa[W-2:0])));

    // R9
    half_zero_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b10 && opa[FW +: EW] == '0) |=> (result == '0));

    // R11
    dbl_zero_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b11 && opa[FW +: EW] == '0) |=> (result == $past(opa)));

    // R12
    lt_low_non_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 2'b00) |=> !lt_flag);
endmodule

// File: tb/test_b64_cmpscale.sv
`timescale 1ns/1ps
module test_b64_cmpscale;
    localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] P_TWO  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] P_HALF = 64'h3FE0_0000_0000_0000;
    localparam logic [63:0] M_ONE  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] M_TWO  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] P_ZERO = 64'h0;
    localparam logic [63:0] M_ZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] UNIT_E = 64'h0010_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  op;
    logic [63:0] opa;
    logic [63:0] opb;
    logic        out_valid;
    logic [63:0] result;
    logic        lt_flag;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference state predicted from the requirements.
    logic        m_valid = 1'b0;
    logic [63:0] m_result = '0;
    logic        m_lt = 1'b0;
    string       res_tag = "R1";
    string       lt_tag  = "R1";

    always #2 clk = ~clk;

    b64_cmpscale i_b64_cmpscale (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opa(opa), .opb(opb), .out_valid(out_valid),
        .result(result), .lt_flag(lt_flag)
    );

    function automatic logic ref_lt(logic [63:0] a, logic [63:0] b);
        if (a[63] && b[63]) return a[62:0] > b[62:0];   // R4 magnitude order reversed
        return $signed(a) < $signed(b);                 // R3
    endfunction

    function automatic logic [63:0] ref_word(logic [1:0] o, logic [63:0] a);
        case (o)
            2'b00: return a;                                   // R6
            2'b01: return {~a[63], a[62:0]};                   // R7
            2'b10: return (a[62:52] == 0) ? 64'h0 : a - UNIT_E; // R8, R9
            default: return (a[62:52] == 0) ? a : a + UNIT_E;  // R10, R11
        endcase
    endfunction

    function automatic string tag_for(logic [1:0] o, logic [63:0] a, logic [63:0] b);
        case (o)
            2'b00: begin
                if ((a == M_ZERO && b == P_ZERO) || (a == P_ZERO && b == M_ZERO)) return "R5";
                if (a[63] && b[63]) return "R4";
                return "R3";
            end
            2'b01: return "R7";
            2'b10: return (a[62:52] == 0) ? "R9" : "R8";
            default: return (a[62:52] == 0) ? "R11" : "R10";
        endcase
    endfunction

    // Compare all outputs against the model in one vector.
    task automatic compare_now();
        n_vec++;
        if (out_valid !== m_valid) begin
            n_fail++;
            $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, m_valid);
        end
        if (result !== m_result) begin
            n_fail++;
            $display("FAIL %s result actual=%h expected=%h", res_tag, result, m_result);
        end
        if (lt_flag !== m_lt) begin
            n_fail++;
            $display("FAIL %s lt_flag actual=%0b expected=%0b", lt_tag, lt_flag, m_lt);
        end
    endtask

    // Drive one cycle at a falling edge, then check one cycle later.
    task automatic apply(logic v, logic [1:0] o, logic [63:0] a, logic [63:0] b);
        in_valid = v; op = o; opa = a; opb = b;
        m_valid = v;
        if (v) begin
            m_result = ref_word(o, a);
            m_lt     = (o == 2'b00) ? ref_lt(a, b) : 1'b0;
            res_tag  = (o == 2'b00) ? "R6" : tag_for(o, a, b);
            lt_tag   = (o == 2'b00) ? tag_for(o, a, b) : "R12";
        end else begin
            res_tag = "R2";
            lt_tag  = "R2";
        end
        @(negedge clk);
        compare_now();
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; op = 2'b01; opa = P_ONE; opb = P_TWO;
        // R1: reset clears the outputs even with a request present
        repeat (3) begin
            @(negedge clk);
            compare_now();
        end
        rst_n = 1'b1;
        // R3
        apply(1, 2'b00, P_ONE, P_TWO);
        apply(1, 2'b00, P_TWO, P_ONE);
        apply(1, 2'b00, M_ONE, P_ONE);
        apply(1, 2'b00, P_ONE, M_ONE);
        apply(1, 2'b00, P_ZERO, P_ZERO);
        // R4
        apply(1, 2'b00, M_TWO, M_ONE);
        apply(1, 2'b00, M_ONE, M_TWO);
        apply(1, 2'b00, M_ONE, M_ONE);
        // R5
        apply(1, 2'b00, M_ZERO, P_ZERO);
        apply(1, 2'b00, P_ZERO, M_ZERO);
        // R2: idle cycles with changing inputs must not move the outputs
        apply(0, 2'b01, P_TWO, P_ONE);
        apply(0, 2'b10, M_TWO, M_ONE);
        // R7
        apply(1, 2'b01, P_ONE, P_ZERO);
        apply(1, 2'b01, M_ZERO, P_ZERO);
        // R12 after a compare that set the flag
        apply(1, 2'b00, M_ZERO, P_ZERO);
        apply(1, 2'b11, P_ONE, P_ZERO);
        // R8 incl. exponent field of one
        apply(1, 2'b10, P_ONE, P_ZERO);
        apply(1, 2'b10, 64'h0010_0000_0000_0005, P_ZERO);
        apply(1, 2'b10, M_TWO, P_ZERO);
        // R9
        apply(1, 2'b10, P_ZERO, P_ZERO);
        apply(1, 2'b10, M_ZERO, P_ZERO);
        // R10
        apply(1, 2'b11, P_HALF, P_ZERO);
        apply(1, 2'b11, M_ONE, P_ZERO);
        // R11
        apply(1, 2'b11, P_ZERO, P_ZERO);
        apply(1, 2'b11, M_ZERO, P_ZERO);
        // Mixed random traffic across all operations
        for (int k = 0; k < 3000; k++) begin
            logic [63:0] ra;
            logic [63:0] rb;
            ra = {$urandom, $urandom};
            rb = ($urandom_range(0, 3) == 0) ? ra : {$urandom, $urandom};
            if ($urandom_range(0, 7) == 0) ra[62:0] = '0;
            apply(($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)), ra, rb);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4ns * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule